// File: doc/BRIEF.md
# APB UART Register Front End

This block is the processor-facing half of a byte-stream UART. It sits on an APB bus as a slave and offers a small register window. Through this window software reads received bytes, writes bytes to send, reads a status word and sets a control word. Received bytes come in on a valid/ready byte port and wait in a receive FIFO whose depth is a parameter. Bytes to send leave through a one-entry holding register on a valid/ready byte port. Bit timing, baud generation and parity belong to a serializer placed behind the two byte ports.

Software polls the status word or waits on a single interrupt line. The interrupt gives a one-cycle pulse when a byte is taken into the FIFO or loaded for sending, provided the matching enable bit is set. Reading the data register takes out the oldest received byte. The data-ready flag follows the FIFO occupancy, so it drops when the last byte is read. The prescaler and FIFO-debug slots decode but read as zero, so drivers that touch them see harmless values.

Top module: `apb_uart_regs`

## Requirements
- R1: After reset the status word reads 0x6, the control word reads 0, the receive FIFO is empty, `tx_valid` is low and `irq` is low.
- R2: Offsets 0x00 and 0x03 both select the data register, 0x04 selects status and 0x08 selects control. A write to 0x08 stores all 32 bits, and a read of 0x08 returns them.
- R3: Writes to the status word, to the prescaler slot (0x0C), to the FIFO-debug slot (0x10) and to unmapped offsets change nothing. Reads of the prescaler slot, the FIFO-debug slot and unmapped offsets return 0.
- R4: A byte offered on `rx_valid` enters the FIFO only while control bit 0 (receive enable) is set. While that bit is clear the byte is consumed and discarded.
- R5: A data-register read in the APB access phase (PSEL, PENABLE, not PWRITE) returns the oldest FIFO byte in bits 7:0, with zeros above, and removes exactly one byte. Setup-phase cycles remove nothing.
- R6: Status bit 0 (data ready) is 1 exactly while the FIFO holds a byte. A data read of an empty FIFO returns 0.
- R7: Status bit 8 is 1 while the occupancy is at least DEPTH/2, and status bit 10 is 1 while the FIFO is full. A byte that arrives while the FIFO is full, with no pop in the same cycle, is dropped and sets status bit 4 (overrun). Bit 4 stays set until reset.
- R8: A data-register write while control bit 1 (transmit enable) is set loads PWDATA[7:0] into `tx_data`, and `tx_valid` rises on the following cycle. `tx_valid` and `tx_data` then hold until `tx_ready` is seen. With bit 1 clear, the write does nothing.
- R9: Status bits 1 and 2 are 1 while the transmit holding register is empty, and status bits 7 and 9 are 1 while it is occupied. A data write that arrives while the register is occupied and not draining in that cycle is dropped.
- R10: `irq` is high for one cycle, the cycle after a byte enters the FIFO while control bit 2 is set, or after a byte is loaded for sending while control bit 3 is set. No other event raises it.
- R11: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset into the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete (constant 1) |
| pslverr | output | 1 | Error response (constant 0) |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive side always takes the byte |
| tx_valid | output | 1 | Byte to send is present |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Serializer takes the byte |
| irq | output | 1 | One-cycle event pulse |

## Verification
Read data is combinational from the current state, so the bench samples `prdata` one time step after raising PENABLE, in the access cycle itself. Every other result follows the access-phase edge or the `rx_valid` edge by exactly one register: FIFO contents, status bits, `tx_valid`/`tx_data` and the `irq` pulse. Each stimulus task therefore returns on the falling edge just after that clock edge, and the bench samples there. It looks at `irq` only at that point, so it catches a missing pulse and also a pulse that lasts more than one cycle, because the next task always begins with a quiet cycle. The full FIFO range is swept in a small configuration with DEPTH of 4, and each status word is predicted from occupancy, overrun and transmit state.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;
    // Register offsets (byte addresses within the window)
    localparam int OFS_DATA        = 'h00;
    localparam int OFS_DATA_NARROW = 'h03;
    localparam int OFS_STAT        = 'h04;
    localparam int OFS_CTRL        = 'h08;

    // Status word bit positions
    localparam int ST_DREADY   = 0;
    localparam int ST_TSH_MT   = 1;
    localparam int ST_THR_MT   = 2;
    localparam int ST_OVERRUN  = 4;
    localparam int ST_THR_HALF = 7;
    localparam int ST_RX_HALF  = 8;
    localparam int ST_THR_FULL = 9;
    localparam int ST_RX_FULL  = 10;

    // Control word bit positions
    localparam int CT_RXEN  = 0;
    localparam int CT_TXEN  = 1;
    localparam int CT_RXIRQ = 2;
    localparam int CT_TXIRQ = 3;

    typedef enum logic [1:0] {
        SEL_ZERO = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/rx_byte_fifo.sv
`timescale 1ns/1ps
module rx_byte_fifo #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [7:0]                   push_data,
    input  logic                         pop,
    output logic [7:0]                   head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         accepted,
    output logic                         dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      wr;
        logic [PTR_W-1:0]      rd;
        logic [CNT_W-1:0]      cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic pop_eff, push_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        pop_eff = pop && (st_q.cnt != '0);
        push_ok = push && ((st_q.cnt != CNT_W'(DEPTH)) || pop_eff);
        if (push_ok) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop_eff) begin
            st_d.rd = bump(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head     = st_q.mem[st_q.rd];
    assign count    = st_q.cnt;
    assign accepted = push_ok;
    assign dropped  = push && !push_ok;

    // R7: occupancy never passes the depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R6: popping an empty FIFO leaves it empty
    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && st_q.cnt == '0 && !push) |=> (st_q.cnt == '0));

    // R5: a lone pop removes exactly one byte
    assert_single_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt != '0) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
endmodule

// File: rtl/tx_hold_reg.sv
`timescale 1ns/1ps
module tx_hold_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       loaded
);
    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;
    logic     free, load_ok;

    always_comb begin
        st_d    = st_q;
        free    = !st_q.valid || tx_ready;
        load_ok = load && free;
        if (load_ok) begin
            st_d.valid = 1'b1;
            st_d.data  = load_data;
        end else if (st_q.valid && tx_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_valid = st_q.valid;
    assign tx_data  = st_q.data;
    assign loaded   = load_ok;

    // R8: an offered byte holds steady until taken
    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/apb_uart_regs.sv
`timescale 1ns/1ps
module apb_uart_regs
    import uart_regs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int HALF  = DEPTH / 2;

    typedef struct packed {
        logic [31:0] ctrl;
        logic        overrun;
        logic        irq;
    } regs_st_t;

    regs_st_t st_d, st_q;

    logic             acc_rd, acc_wr;
    reg_sel_e         sel;
    logic             fifo_push, fifo_pop, rx_took, rx_drop;
    logic [7:0]       fifo_head;
    logic [CNT_W-1:0] fifo_cnt;
    logic             tx_load, tx_took;
    logic [31:0]      status_w;

    // Address decode
    always_comb begin
        acc_rd = psel && penable && !pwrite;
        acc_wr = psel && penable && pwrite;
        if (paddr == ADDR_W'(OFS_DATA) || paddr == ADDR_W'(OFS_DATA_NARROW))
            sel = SEL_DATA;
        else if (paddr == ADDR_W'(OFS_STAT))
            sel = SEL_STAT;
        else if (paddr == ADDR_W'(OFS_CTRL))
            sel = SEL_CTRL;
        else
            sel = SEL_ZERO;
    end

    assign fifo_push = rx_valid && st_q.ctrl[CT_RXEN];
    assign fifo_pop  = acc_rd && (sel == SEL_DATA);
    assign tx_load   = acc_wr && (sel == SEL_DATA) && st_q.ctrl[CT_TXEN];

    rx_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
        .clk       (pclk),
        .rst_n     (presetn),
        .push      (fifo_push),
        .push_data (rx_data),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_cnt),
        .accepted  (rx_took),
        .dropped   (rx_drop)
    );

    tx_hold_reg u_tx_hold (
        .clk       (pclk),
        .rst_n     (presetn),
        .load      (tx_load),
        .load_data (pwdata[7:0]),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .loaded    (tx_took)
    );

    // Status word assembly
    always_comb begin
        status_w              = '0;
        status_w[ST_DREADY]   = (fifo_cnt != '0);
        status_w[ST_TSH_MT]   = !tx_valid;
        status_w[ST_THR_MT]   = !tx_valid;
        status_w[ST_OVERRUN]  = st_q.overrun;
        status_w[ST_THR_HALF] = tx_valid;
        status_w[ST_RX_HALF]  = (fifo_cnt >= CNT_W'(HALF));
        status_w[ST_THR_FULL] = tx_valid;
        status_w[ST_RX_FULL]  = (fifo_cnt == CNT_W'(DEPTH));
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (acc_wr && sel == SEL_CTRL)
            st_d.ctrl = pwdata;
        st_d.overrun = st_q.overrun || rx_drop;
        st_d.irq     = (rx_took && st_q.ctrl[CT_RXIRQ]) ||
                       (tx_took && st_q.ctrl[CT_TXIRQ]);
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) st_q <= '0;
        else          st_q <= st_d;
    end

    // Read mux
    always_comb begin
        unique case (sel)
            SEL_DATA: prdata = (fifo_cnt != '0) ? {24'd0, fifo_head} : 32'd0;
            SEL_STAT: prdata = status_w;
            SEL_CTRL: prdata = st_q.ctrl;
            default:  prdata = 32'd0;
        endcase
    end

    assign pready   = 1'b1;
    assign pslverr  = 1'b0;
    assign rx_ready = 1'b1;
    assign irq      = st_q.irq;

    // R4: occupancy cannot grow while receive is disabled
    assert_rx_gate_R4: assert property (@(posedge pclk) disable iff (!presetn)
        !st_q.ctrl[CT_RXEN] |=> (fifo_cnt <= $past(fifo_cnt)));

    // R7: overrun is sticky
    assert_overrun_sticky_R7: assert property (@(posedge pclk) disable iff (!presetn)
        st_q.overrun |=> st_q.overrun);

    // R8: a new transmit byte only appears with transmit enabled
    assert_tx_gate_R8: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(tx_valid) |-> $past(st_q.ctrl[CT_TXEN]));

    // R10: a pulse needs one of the interrupt enables
    assert_irq_cause_R10: assert property (@(posedge pclk) disable iff (!presetn)
        irq |-> $past(st_q.ctrl[CT_RXIRQ] || st_q.ctrl[CT_TXIRQ]));
endmodule

// File: tb/test_apb_uart_regs.sv
`timescale 1ns/1ps
module test_apb_uart_regs;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 8;

    logic              pclk = 1'b0;
    logic              presetn = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic              pready, pslverr;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_ready;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b0;
    logic              irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 pclk = ~pclk;

    apb_uart_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_apb_uart_regs (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input int cnt, input bit ovr, input bit busy);
        logic [31:0] s = '0;
        s[0]  = (cnt != 0);
        s[1]  = !busy;
        s[2]  = !busy;
        s[4]  = ovr;
        s[7]  = busy;
        s[8]  = (cnt >= DEPTH/2);
        s[9]  = busy;
        s[10] = (cnt == DEPTH);
        return s;
    endfunction

    task automatic apb_write(input int addr, input logic [31:0] val);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = ADDR_W'(addr); pwdata = val;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input int addr, input int setup_n, output logic [31:0] val);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = ADDR_W'(addr);
        for (int i = 1; i < setup_n; i++) @(negedge pclk);
        @(negedge pclk);
        penable = 1'b1;
        #1 val = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge pclk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge pclk);
        rx_valid = 1'b0;
    endtask

    task automatic drain_tx();
        @(negedge pclk);
        tx_ready = 1'b1;
        @(negedge pclk);
        tx_ready = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge pclk);
        presetn = 1'b0;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        do_reset();

        // R1 reset state, R11 fixed response
        apb_read(4, 1, rd);  chk("R1 status", rd, 32'h6);
        apb_read(8, 1, rd);  chk("R1 control", rd, 32'h0);
        apb_read(0, 1, rd);  chk("R1 fifo empty", rd, 32'h0);
        chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R11 pready", {31'd0, pready}, 32'd1);
        chk("R11 pslverr", {31'd0, pslverr}, 32'd0);

        // R2 control full-width readback
        apb_write(8, 32'hA5A5_1230);
        apb_read(8, 1, rd);  chk("R2 control readback", rd, 32'hA5A5_1230);
        apb_write(8, 32'h0);

        // R3 writes everywhere but control; R8 data writes with tx disabled
        for (int a = 0; a < 32; a++) begin
            if (a != 8) apb_write(a, 32'hFFFF_FFFF);
        end
        chk("R8 disabled write no tx", {31'd0, tx_valid}, 32'd0);
        for (int a = 0; a < 32; a++) begin
            logic [31:0] e;
            e = (a == 4) ? 32'h6 : 32'h0;
            apb_read(a, 1, rd);
            chk($sformatf("R3 read offset 0x%02h", a), rd, e);
        end

        // R4 receive disabled: byte discarded
        send_rx(8'h11);
        chk("R4 no irq when disabled", {31'd0, irq}, 32'd0);
        apb_read(4, 1, rd);  chk("R4 status unchanged", rd, exp_status(0, 0, 0));

        // R6/R7/R10 fill sweep with receive irq
        apb_write(8, 32'h5);
        for (int k = 0; k < DEPTH; k++) begin
            send_rx(8'((k * 37 + 5) & 255));
            chk($sformatf("R10 rx irq byte %0d", k), {31'd0, irq}, 32'd1);
            apb_read(4, 1, rd);
            chk($sformatf("R7 status at %0d", k + 1), rd, exp_status(k + 1, 0, 0));
        end
        send_rx(8'hEE);
        chk("R7 dropped byte no irq", {31'd0, irq}, 32'd0);
        apb_read(4, 1, rd);  chk("R7 overrun set", rd, exp_status(DEPTH, 1, 0));

        // R5 order, narrow offset, long setup phases
        for (int i = 0; i < DEPTH; i++) begin
            apb_read((i % 2) ? 3 : 0, i + 1, rd);
            chk($sformatf("R5 byte %0d", i), rd, 32'((i * 37 + 5) & 255));
            apb_read(4, 1, rd);
            chk($sformatf("R6 status after pop %0d", i), rd, exp_status(DEPTH - 1 - i, 1, 0));
        end
        apb_read(0, 1, rd);  chk("R6 empty read zero", rd, 32'h0);
        apb_read(4, 1, rd);  chk("R7 overrun sticky", rd, exp_status(0, 1, 0));

        // R8/R9/R10 transmit with irq
        apb_write(8, 32'hF);
        apb_write(3, 32'h1234_56C3);
        chk("R10 tx irq", {31'd0, irq}, 32'd1);
        chk("R8 tx_valid", {31'd0, tx_valid}, 32'd1);
        chk("R8 tx_data low byte", {24'd0, tx_data}, 32'hC3);
        apb_read(4, 1, rd);  chk("R9 busy status", rd, exp_status(0, 1, 1));
        apb_write(0, 32'h77);
        chk("R9 busy write no irq", {31'd0, irq}, 32'd0);
        chk("R9 busy write dropped", {24'd0, tx_data}, 32'hC3);
        drain_tx();
        chk("R8 drained", {31'd0, tx_valid}, 32'd0);
        apb_read(4, 1, rd);  chk("R9 idle status", rd, exp_status(0, 1, 0));

        // R10 transmit without irq enable
        apb_write(8, 32'h2);
        apb_write(0, 32'hAB);
        chk("R10 no tx irq", {31'd0, irq}, 32'd0);
        chk("R8 tx_data AB", {24'd0, tx_data}, 32'hAB);
        drain_tx();

        // R8 disabled transmit
        apb_write(8, 32'h0);
        apb_write(0, 32'hCD);
        chk("R8 disabled no valid", {31'd0, tx_valid}, 32'd0);

        // R10 receive without irq enable
        apb_write(8, 32'h1);
        send_rx(8'h42);
        chk("R10 no rx irq", {31'd0, irq}, 32'd0);
        apb_read(4, 1, rd);  chk("R6 data ready", rd, exp_status(1, 1, 0));

        // R1 reset clears fifo and overrun
        do_reset();
        apb_read(4, 1, rd);  chk("R1 status after reset", rd, 32'h6);
        apb_read(0, 1, rd);  chk("R1 fifo flushed", rd, 32'h0);
        apb_read(8, 1, rd);  chk("R1 control cleared", rd, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule